// File: doc/BRIEF.md
# DMA Event Interrupt Aggregator

This block gathers the event pulses of a four-channel DMA engine and turns them into one CPU interrupt line. There are two kinds of event source. Each channel has its own 32-bit event vector. A shared common group holds the slave-interface access errors and the ECC errors of two master interfaces. Every source has a bank with three parts: a capture mask, a propagation mask and a sticky status word.

A pulse is recorded in the status word only when its capture-mask bit is set. A recorded bit counts toward the interrupt only when its propagation-mask bit is also set. A summary word shows which banks have propagated bits pending: channel n at bit n and the common group at bit 16. The CPU line is the registered OR of the summary, gated by a global enable. Software clears status by writing a mask to a per-bank clear location.

Registers are reached through a plain one-cycle write port and a combinational read port. The 5-bit address is split into a page (bits 4:2) and a register within the page (bits 1:0).

Top module: `dma_irq_agg`

## Requirements
- R1: After reset, every readable location reads 0 and irq_o is 0.
- R2: An event pulse sets its status bit on the next clock edge only when the bank's capture-mask bit is set. With the capture-mask bit clear, the pulse leaves status unchanged.
- R3: Only implemented bit positions can be stored; all other positions read 0 in the mask and status registers. Channel banks implement bits 0, 1, 3 to 13 and 27 to 31 (0xF8003FFB). The common bank implements bits 0 to 3 and 7 to 20 (0x001FFF8F).
- R4: Writing a mask to a bank's clear location (register 3) clears exactly the status bits set in the mask. The clear location always reads 0.
- R5: When an event is captured in the same cycle as a clear of the same bit, the bit stays set.
- R6: Summary bit n is set when channel n has a status bit whose propagation-mask bit is also set. Bit 16 does the same for the common bank. All other summary bits read 0.
- R7: irq_o equals, one clock later, the global enable ANDed with the OR of the summary bits.
- R8: With the global enable (page 0, register 0, bit 0) clear, irq_o stays 0 while status keeps capturing events.
- R9: Status bits are sticky. Clearing a capture-mask bit, or changing the propagation mask, does not alter status already recorded.
- R10: A mask write takes effect from the next cycle. An event arriving in the same cycle as the write is judged against the old mask.
- R11: Page 0 holds the global enable (register 0) and the read-only summary (register 1). Page 1 is the common bank, and page 2+n is channel n. Within a bank, register 0 is the capture mask, 1 is the propagation mask, 2 is the read-only status and 3 is the clear location. Unmapped pages read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ch_evt_i | input | 128 | Channel event pulses; channel n uses bits 32n+31:32n |
| cmn_evt_i | input | 21 | Common-group event pulses |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Write address {page, register} |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 5 | Read address {page, register} |
| rd_data_o | output | 32 | Combinational read data |
| irq_o | output | 1 | Registered CPU interrupt |

## Verification
Events, clears and mask writes act on the clock edge after they are driven. The status, mask and summary readback therefore shows the change one edge later, and irq_o follows the summary one edge after that. The bench drives inputs just after a falling edge. A behavioural model updates on the rising edge in exactly this order, and the bench compares the read port and irq_o at every falling edge. This catches both an early response and a late response. The same-cycle cases (event against clear, event against mask write) are driven in a single cycle so that each ordering is resolved at one edge.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int DATA_W      = 32;
  localparam int CMN_EVT_W   = 21;
  localparam int SUM_CMN_BIT = 16;
  // implemented event positions
  localparam logic [DATA_W-1:0] CH_EVT_VALID  = 32'hF800_3FFB;
  localparam logic [DATA_W-1:0] CMN_EVT_VALID = 32'h001F_FF8F;

  typedef enum logic [1:0] {
    REG_STEN = 2'd0,
    REG_SGEN = 2'd1,
    REG_STAT = 2'd2,
    REG_CLR  = 2'd3
  } bank_reg_e;
endpackage

// File: rtl/dma_irq_bank.sv
module dma_irq_bank
  import dma_irq_pkg::*;
#(
  parameter int                W     = DATA_W,
  parameter logic [W-1:0]      VALID = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         sten_we_i,
  input  logic         sgen_we_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] stat_en_o,
  output logic [W-1:0] sig_en_o,
  output logic [W-1:0] status_o,
  output logic         pend_o
);
  logic [W-1:0] stat_en_q, sig_en_q, status_q;
  logic [W-1:0] clr_mask, capt, status_d;

  assign clr_mask = clr_we_i ? wr_data_i : '0;
  assign capt     = evt_i & stat_en_q;
  // capture overrides a same-cycle clear
  assign status_d = (status_q & ~clr_mask) | capt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_en_q <= '0;
      sig_en_q  <= '0;
      status_q  <= '0;
    end else begin
      if (sten_we_i) stat_en_q <= wr_data_i & VALID;
      if (sgen_we_i) sig_en_q  <= wr_data_i & VALID;
      status_q <= status_d;
    end
  end

  assign stat_en_o = stat_en_q;
  assign sig_en_o  = sig_en_q;
  assign status_o  = status_q;
  assign pend_o    = |(status_q & sig_en_q);

  assert_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(evt_i & stat_en_o) |=> ((status_o & $past(evt_i & stat_en_o)) == $past(evt_i & stat_en_o)));

  assert_evt_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((status_o & $past(wr_data_i & ~(evt_i & stat_en_o))) == '0));

  assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_we_i && !(|(evt_i & stat_en_o))) |=> (status_o == $past(status_o)));

  assert_unimpl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_o | stat_en_o | sig_en_o) & ~VALID) == '0);
endmodule

// File: rtl/dma_irq_summary.sv
module dma_irq_summary
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] pend_ch_i,
  input  logic              pend_cmn_i,
  input  logic              glb_en_i,
  output logic [DATA_W-1:0] summary_o,
  output logic              irq_o
);
  logic irq_q;

  always_comb begin
    summary_o = '0;
    for (int n = 0; n < NUM_CH; n++) summary_o[n] = pend_ch_i[n];
    summary_o[SUM_CMN_BIT] = pend_cmn_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= glb_en_i & (|summary_o);
  end

  assign irq_o = irq_q;

  assert_irq_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|{pend_ch_i, pend_cmn_i}));

  assert_glb_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_en_i |=> !irq_o);

  assert_sum_onehot_cmn_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(summary_o) == $countones({pend_ch_i, pend_cmn_i}));
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = $clog2(NUM_CH + 2) + 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_CH*DATA_W-1:0]   ch_evt_i,
  input  logic [CMN_EVT_W-1:0]       cmn_evt_i,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  output logic [DATA_W-1:0]          rd_data_o,
  output logic                       irq_o
);
  localparam int NUM_BANK = NUM_CH + 1;   // bank 0 common, bank 1+n channel n
  localparam int PAGE_W   = ADDR_W - 2;

  logic [PAGE_W-1:0] wr_page, rd_page;
  bank_reg_e         wr_reg, rd_reg;
  logic              glb_en_q;
  logic [DATA_W-1:0] summary;

  logic [DATA_W-1:0] sten_a   [NUM_BANK];
  logic [DATA_W-1:0] sgen_a   [NUM_BANK];
  logic [DATA_W-1:0] status_a [NUM_BANK];
  logic [NUM_BANK-1:0] pend;

  assign wr_page = wr_addr_i[ADDR_W-1:2];
  assign wr_reg  = bank_reg_e'(wr_addr_i[1:0]);
  assign rd_page = rd_addr_i[ADDR_W-1:2];
  assign rd_reg  = bank_reg_e'(rd_addr_i[1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) glb_en_q <= 1'b0;
    else if (wr_en_i && wr_page == '0 && wr_reg == REG_STEN) glb_en_q <= wr_data_i[0];
  end

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    logic              sel;
    logic [DATA_W-1:0] evt;
    assign sel = wr_en_i && (wr_page == PAGE_W'(b + 1));
    if (b == 0) begin : g_cmn
      assign evt = {{(DATA_W-CMN_EVT_W){1'b0}}, cmn_evt_i};
    end else begin : g_ch
      assign evt = ch_evt_i[(b-1)*DATA_W +: DATA_W];
    end
    dma_irq_bank #(
      .W     (DATA_W),
      .VALID ((b == 0) ? CMN_EVT_VALID : CH_EVT_VALID)
    ) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (evt),
      .sten_we_i (sel && wr_reg == REG_STEN),
      .sgen_we_i (sel && wr_reg == REG_SGEN),
      .clr_we_i  (sel && wr_reg == REG_CLR),
      .wr_data_i (wr_data_i),
      .stat_en_o (sten_a[b]),
      .sig_en_o  (sgen_a[b]),
      .status_o  (status_a[b]),
      .pend_o    (pend[b])
    );
  end

  dma_irq_summary #(.NUM_CH(NUM_CH)) u_summary (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pend_ch_i  (pend[NUM_BANK-1:1]),
    .pend_cmn_i (pend[0]),
    .glb_en_i   (glb_en_q),
    .summary_o  (summary),
    .irq_o      (irq_o)
  );

  always_comb begin
    rd_data_o = '0;
    if (rd_page == '0) begin
      if (rd_reg == REG_STEN)      rd_data_o = {{(DATA_W-1){1'b0}}, glb_en_q};
      else if (rd_reg == REG_SGEN) rd_data_o = summary;
    end else begin
      for (int b = 0; b < NUM_BANK; b++) begin
        if (rd_page == PAGE_W'(b + 1)) begin
          case (rd_reg)
            REG_STEN: rd_data_o = sten_a[b];
            REG_SGEN: rd_data_o = sgen_a[b];
            REG_STAT: rd_data_o = status_a[b];
            default:  rd_data_o = '0;
          endcase
        end
      end
    end
  end

  assert_irq_reset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !irq_o);

  assert_clr_reads_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_page != '0 && rd_reg == REG_CLR) |-> rd_data_o == '0);

  assert_glb_gate_top_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(glb_en_q) |=> !irq_o);
endmodule

// File: tb/dma_irq_agg_tb.sv
module dma_irq_agg_tb;
  localparam int NCH = 4;
  localparam int NB  = NCH + 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NCH*32-1:0] ch_evt = '0;
  logic [20:0]     cmn_evt = '0;
  logic            wr_en = 1'b0;
  logic [4:0]      wr_addr = '0;
  logic [31:0]     wr_data = '0;
  logic [4:0]      rd_addr = '0;
  logic [31:0]     rd_data;
  logic            irq;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  dma_irq_agg u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ch_evt_i(ch_evt), .cmn_evt_i(cmn_evt),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
  );

  // behavioural reference: index 0 common, 1+n channel n
  logic [31:0] m_sten [NB];
  logic [31:0] m_sgen [NB];
  logic [31:0] m_stat [NB];
  logic        m_glb = 1'b0;
  logic        m_irq = 1'b0;

  initial for (int b = 0; b < NB; b++) begin
    m_sten[b] = '0; m_sgen[b] = '0; m_stat[b] = '0;
  end

  function automatic logic [31:0] vmask(int b);
    return (b == 0) ? 32'h001F_FF8F : 32'hF800_3FFB;
  endfunction

  function automatic logic [31:0] m_summary();
    logic [31:0] s = '0;
    for (int k = 0; k < NCH; k++) if ((m_stat[k+1] & m_sgen[k+1]) != 0) s[k] = 1'b1;
    if ((m_stat[0] & m_sgen[0]) != 0) s[16] = 1'b1;
    return s;
  endfunction

  function automatic logic [31:0] bank_evt(int b);
    if (b == 0) return {11'b0, cmn_evt};
    return ch_evt[(b-1)*32 +: 32];
  endfunction

  function automatic logic [31:0] exp_rd(logic [4:0] a);
    int pg = int'(a[4:2]);
    int r  = int'(a[1:0]);
    if (pg == 0) begin
      if (r == 0) return {31'b0, m_glb};
      if (r == 1) return m_summary();
      return '0;
    end
    if (pg <= NB) begin
      if (r == 0) return m_sten[pg-1];
      if (r == 1) return m_sgen[pg-1];
      if (r == 2) return m_stat[pg-1];
    end
    return '0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin
        m_sten[b] = '0; m_sgen[b] = '0; m_stat[b] = '0;
      end
      m_glb = 1'b0;
      m_irq = 1'b0;
    end else begin
      logic [31:0] nx_stat [NB];
      m_irq = m_glb && (m_summary() != 0);
      for (int b = 0; b < NB; b++) begin
        nx_stat[b] = m_stat[b];
        if (wr_en && int'(wr_addr[4:2]) == b + 1 && wr_addr[1:0] == 2'd3)
          nx_stat[b] = nx_stat[b] & ~wr_data;
        nx_stat[b] = nx_stat[b] | (bank_evt(b) & m_sten[b]);
      end
      for (int b = 0; b < NB; b++) begin
        m_stat[b] = nx_stat[b];
        if (wr_en && int'(wr_addr[4:2]) == b + 1) begin
          if (wr_addr[1:0] == 2'd0) m_sten[b] = wr_data & vmask(b);
          if (wr_addr[1:0] == 2'd1) m_sgen[b] = wr_data & vmask(b);
        end
      end
      if (wr_en && wr_addr == 5'd0) m_glb = wr_data[0];
    end
  end

  task automatic cyc();
    logic [31:0] e;
    @(negedge clk);
    e = exp_rd(rd_addr);
    checks++;
    if (rd_data !== e) begin
      fails++;
      $display("FAIL %s rd_data @%0h actual %08h expected %08h", cur_req, rd_addr, rd_data, e);
    end
    checks++;
    if (irq !== m_irq) begin
      fails++;
      $display("FAIL %s irq_o actual %0b expected %0b", cur_req, irq, m_irq);
    end
    wr_en = 1'b0; ch_evt = '0; cmn_evt = '0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
  endtask

  task automatic sweep();
    for (int a = 0; a < 32; a++) begin
      rd_addr = 5'(a);
      cyc();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    cur_req = "R1";
    repeat (3) cyc();
    rst_n = 1'b1;
    sweep();

    // R2 capture gated by capture mask
    cur_req = "R2";
    rd_addr = 5'h0A;
    ch_evt[0] = 1'b1; cyc(); cyc();
    wr(5'h08, 32'h1);
    ch_evt[1:0] = 2'b11; cyc(); cyc();

    // R3 unimplemented positions
    cur_req = "R3";
    wr(5'h0C, 32'hFFFF_FFFF);
    wr(5'h04, 32'hFFFF_FFFF);
    rd_addr = 5'h0C; cyc();
    rd_addr = 5'h04; cyc();
    ch_evt[63:32] = '1; cmn_evt = '1; cyc();
    rd_addr = 5'h0E; cyc();
    rd_addr = 5'h06; cyc();

    // R6 summary mapping
    cur_req = "R6";
    rd_addr = 5'h01;
    wr(5'h0D, 32'h1); cyc();
    wr(5'h05, 32'h80); cyc();
    wr(5'h09, 32'h0000_0002); cyc();

    // R8 global gate
    cur_req = "R8";
    repeat (3) cyc();
    rd_addr = 5'h00;
    wr(5'h00, 32'h1); cyc(); cyc();

    // R7 latency on falling summary
    cur_req = "R7";
    rd_addr = 5'h01;
    wr(5'h07, 32'hFFFF_FFFF); cyc();
    wr(5'h0F, 32'hFFFF_FFFF); cyc();
    wr(5'h0B, 32'hFFFF_FFFF); cyc(); cyc();

    // R4 selective clear
    cur_req = "R4";
    wr(5'h08, 32'h3);
    ch_evt[1:0] = 2'b11; cyc();
    rd_addr = 5'h0A; cyc();
    wr(5'h0B, 32'h0); cyc();
    wr(5'h0B, 32'h1); cyc();
    rd_addr = 5'h0B; cyc();

    // R5 event beats clear
    cur_req = "R5";
    rd_addr = 5'h0A;
    wr_en = 1'b1; wr_addr = 5'h0B; wr_data = 32'h2; ch_evt[1] = 1'b1; cyc();
    cyc();

    // R10 mask write timing
    cur_req = "R10";
    rd_addr = 5'h16;
    wr_en = 1'b1; wr_addr = 5'h14; wr_data = 32'h10; ch_evt[3*32+4] = 1'b1; cyc();
    cyc();
    ch_evt[3*32+4] = 1'b1; cyc(); cyc();
    wr(5'h15, 32'h10); cyc(); cyc();

    // R9 sticky against mask changes
    cur_req = "R9";
    wr(5'h14, 32'h0); cyc();
    wr(5'h15, 32'h0); cyc();
    ch_evt[3*32+5] = 1'b1; cyc();
    rd_addr = 5'h01; cyc();

    // R11 map and unmapped pages
    cur_req = "R11";
    wr(5'h18, 32'hFFFF_FFFF);
    wr(5'h1C, 32'hFFFF_FFFF);
    wr(5'h01, 32'hFFFF_FFFF);
    wr(5'h12, 32'hFFFF_FFFF);
    sweep();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule